// File: doc/BRIEF.md
# Indirect Banked Register Access Unit

This block is the register side of a management-interface slave. It presents a small set of directly addressed 16-bit registers on a simple synchronous port with a 5-bit address, a write strobe and a read strobe. Behind those registers sit several hidden register banks of 32 entries each. Software reaches a hidden entry indirectly: it loads a staging register with write data, or issues a read, through a single control word that packs the command, the bank number and the entry address. Serial framing on the management wire is handled elsewhere.

The hidden banks are locked by default. They open only after an exact four-step sequence of control-register writes that toggles a test-mode bit. While the banks are open, a control write that carries exactly one command moves one 16-bit value between a bank entry and the data registers. A control write with the test-mode bit clear locks the banks again.

Top module: `bank_gate_regs`

## Requirements
- R1: After reset every hidden bank entry and every direct register reads 0 and bank access is locked.
- R2: A write to direct address 23 stores the staging write data, and a read of address 23 returns it.
- R3: Bank access opens only after four consecutive writes to address 20 with the values 0x0000, 0x0400, 0x0000, 0x0400 (bit 10 is the test-mode bit).
- R4: A control write that breaks the unlock sequence sends the tracker back to its start; if that write is 0x0000 it counts as the first step of a new sequence.
- R5: While open, any control write with bit 10 clear (including 0x0000) locks bank access again.
- R6: While open, a control write with bit 14 set, bit 15 clear and bit 10 set stores the address-23 value into the entry selected by bank bits 12:11 and entry address bits 4:0.
- R7: While open, a control write with bit 15 set, bit 14 clear and bit 10 set copies the entry selected by bank bits 12:11 and entry address bits 9:5 into address 21 at that clock edge, so the next read of address 21 returns it.
- R8: A command received while access is locked changes neither address 21 nor any bank entry.
- R9: A command selecting bank 2, or setting both bit 15 and bit 14, performs no access; banks 0, 1 and 3 exist.
- R10: The same entry address in different banks refers to separate storage.
- R11: A read of address 20 returns the last control word written; reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the direct register port |
| rd_en | input | 1 | Read strobe for the direct register port |
| addr | input | 5 | Direct register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle rd_en is high, 0 otherwise |

## Verification
The assertions assume that a write strobe lasts one cycle per transaction and that wr_en and rd_en are never both high, so that a control write and a read of the fetched data never share an edge. They also assume that inputs are quiet while reset is asserted. The stimulus drives one transaction at a time on the falling edge, holds each strobe for exactly one rising edge, and keeps every strobe low during reset.

// File: rtl/bgr_pkg.sv
package bgr_pkg;

    localparam int DATA_W    = 16;
    localparam int REG_AW    = 5;

    // direct register map (behaviour-relevant positions)
    localparam logic [REG_AW-1:0] A_CTRL  = 5'd20;
    localparam logic [REG_AW-1:0] A_FETCH = 5'd21;
    localparam logic [REG_AW-1:0] A_STAGE = 5'd23;

    // control word fields
    localparam int CB_RD      = 15;
    localparam int CB_WR      = 14;
    localparam int CB_BANK_HI = 12;
    localparam int CB_BANK_LO = 11;
    localparam int CB_TM      = 10;
    localparam int CB_RA_HI   = 9;
    localparam int CB_RA_LO   = 5;
    localparam int CB_WA_HI   = 4;
    localparam int CB_WA_LO   = 0;

    localparam logic [DATA_W-1:0] TM_ONLY = 16'h0400;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM1 = 3'd1,
        ST_ARM2 = 3'd2,
        ST_ARM3 = 3'd3,
        ST_OPEN = 3'd4
    } gate_st_e;

endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
    import bgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_data,
    output logic              open_o
);

    typedef struct packed {
        gate_st_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    logic is_zero, is_tm;

    always_comb begin
        is_zero = (ctrl_data == '0);
        is_tm   = (ctrl_data == TM_ONLY);
        seq_d   = seq_q;
        if (ctrl_we) begin
            unique case (seq_q.st)
                ST_IDLE: seq_d.st = is_zero ? ST_ARM1 : ST_IDLE;
                ST_ARM1: seq_d.st = is_tm ? ST_ARM2 : (is_zero ? ST_ARM1 : ST_IDLE);
                ST_ARM2: seq_d.st = is_zero ? ST_ARM3 : ST_IDLE;
                ST_ARM3: seq_d.st = is_tm ? ST_OPEN : (is_zero ? ST_ARM1 : ST_IDLE);
                ST_OPEN: begin
                    if (!ctrl_data[CB_TM])
                        seq_d.st = is_zero ? ST_ARM1 : ST_IDLE;
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE};
        else        seq_q <= seq_d;
    end

    assign open_o = (seq_q.st == ST_OPEN);

    // R5
    close_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_data[CB_TM]) |=> !open_o);

    // R3
    open_needs_arm3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && !(ctrl_we && seq_q.st == ST_ARM3 && ctrl_data == TM_ONLY)) |=> !open_o);

    // R4
    zero_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_data == '0) |=> (seq_q.st == ST_ARM1 || seq_q.st == ST_ARM3));

endmodule

// File: rtl/bank_store.sv
module bank_store #(
    parameter int ENTRIES = 32,
    parameter int WIDTH   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.mem[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[raddr];

    // R6
    entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (st_q.mem[$past(waddr)] == $past(wdata)));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.mem));

endmodule

// File: rtl/bank_gate_regs.sv
module bank_gate_regs
    import bgr_pkg::*;
#(
    parameter int          BANK_SLOTS   = 4,
    parameter int          BANK_ENTRIES = 32,
    parameter logic [3:0]  BANK_PRESENT = 4'b1011,
    localparam int         BSEL_W       = $clog2(BANK_SLOTS),
    localparam int         IDX_W        = $clog2(BANK_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] fetch;
        logic [DATA_W-1:0] stage;
    } dir_t;

    dir_t dir_d, dir_q;

    logic                               ctrl_we;
    logic                               open;
    logic [BSEL_W-1:0]                  bsel;
    logic [IDX_W-1:0]                   ra, wa;
    logic                               cmd_ok, do_rd, do_wr;
    logic [BANK_SLOTS-1:0]              bank_we;
    logic [BANK_SLOTS-1:0][DATA_W-1:0]  bank_rd;

    assign ctrl_we = wr_en && (addr == A_CTRL);
    assign bsel    = wdata[CB_BANK_HI:CB_BANK_LO];
    assign ra      = wdata[CB_RA_HI:CB_RA_LO];
    assign wa      = wdata[CB_WA_HI:CB_WA_LO];

    unlock_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_data (wdata),
        .open_o    (open)
    );

    assign cmd_ok = ctrl_we && open && wdata[CB_TM] && BANK_PRESENT[bsel]
                    && (wdata[CB_RD] ^ wdata[CB_WR]);
    assign do_rd  = cmd_ok && wdata[CB_RD];
    assign do_wr  = cmd_ok && wdata[CB_WR];

    for (genvar b = 0; b < BANK_SLOTS; b++) begin : g_bank
        if (BANK_PRESENT[b]) begin : g_live
            assign bank_we[b] = do_wr && (bsel == BSEL_W'(b));
            bank_store #(
                .ENTRIES (BANK_ENTRIES),
                .WIDTH   (DATA_W)
            ) u_store (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (bank_we[b]),
                .waddr (wa),
                .wdata (dir_q.stage),
                .raddr (ra),
                .rdata (bank_rd[b])
            );
        end else begin : g_hole
            assign bank_we[b] = 1'b0;
            assign bank_rd[b] = '0;
        end
    end

    always_comb begin
        dir_d = dir_q;
        if (ctrl_we) dir_d.ctrl = wdata;
        if (wr_en && addr == A_STAGE) dir_d.stage = wdata;
        if (do_rd) dir_d.fetch = bank_rd[bsel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_CTRL:  rdata = dir_q.ctrl;
                A_FETCH: rdata = dir_q.fetch;
                A_STAGE: rdata = dir_q.stage;
                default: rdata = '0;
            endcase
        end
    end

    // R8
    locked_fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !open) |=> $stable(dir_q.fetch));

    // R9
    hole_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && (!BANK_PRESENT[bsel] || (wdata[CB_RD] && wdata[CB_WR])))
        |=> $stable(dir_q.fetch));

    // R9
    single_bank_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAGE) |=> (dir_q.stage == $past(wdata)));

endmodule

// File: tb/bank_gate_regs_bench.sv
module bank_gate_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bank_gate_regs u_bank_gate_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // vector: {check, req, addr, data, expect}; check=0 write, 1 read-and-compare
    localparam int NV = 34;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 4'd3,  5'd20, 16'h0000, 16'h0000},  // R3 unlock step 1
        {1'b0, 4'd3,  5'd20, 16'h0400, 16'h0000},
        {1'b0, 4'd3,  5'd20, 16'h0000, 16'h0000},
        {1'b0, 4'd3,  5'd20, 16'h0400, 16'h0000},
        {1'b0, 4'd2,  5'd23, 16'h1234, 16'h0000},  // R2
        {1'b1, 4'd2,  5'd23, 16'h0000, 16'h1234},
        {1'b0, 4'd6,  5'd20, 16'h5C05, 16'h0000},  // R6 bank3 entry5
        {1'b0, 4'd6,  5'd23, 16'hABCD, 16'h0000},
        {1'b0, 4'd6,  5'd20, 16'h4C05, 16'h0000},  // bank1 entry5
        {1'b0, 4'd6,  5'd23, 16'h0F0F, 16'h0000},
        {1'b0, 4'd6,  5'd20, 16'h4405, 16'h0000},  // bank0 entry5
        {1'b0, 4'd7,  5'd20, 16'h9CA0, 16'h0000},  // R7 read bank3 entry5
        {1'b1, 4'd7,  5'd21, 16'h0000, 16'h1234},
        {1'b1, 4'd11, 5'd20, 16'h0000, 16'h9CA0},  // R11
        {1'b0, 4'd10, 5'd20, 16'h8CA0, 16'h0000},  // R10 bank1
        {1'b1, 4'd10, 5'd21, 16'h0000, 16'hABCD},
        {1'b0, 4'd10, 5'd20, 16'h84A0, 16'h0000},  // bank0
        {1'b1, 4'd10, 5'd21, 16'h0000, 16'h0F0F},
        {1'b0, 4'd9,  5'd23, 16'h5555, 16'h0000},  // R9 bank2 write
        {1'b0, 4'd9,  5'd20, 16'h5405, 16'h0000},
        {1'b0, 4'd9,  5'd20, 16'h94A0, 16'h0000},  // bank2 read
        {1'b1, 4'd9,  5'd21, 16'h0000, 16'h0F0F},
        {1'b0, 4'd9,  5'd20, 16'hDCA5, 16'h0000},  // both bits
        {1'b1, 4'd9,  5'd21, 16'h0000, 16'h0F0F},
        {1'b0, 4'd9,  5'd20, 16'h9CA0, 16'h0000},
        {1'b1, 4'd9,  5'd21, 16'h0000, 16'h1234},
        {1'b0, 4'd8,  5'd20, 16'h9CE0, 16'h0000},  // R8 locked write earlier
        {1'b1, 4'd8,  5'd21, 16'h0000, 16'h0000},
        {1'b0, 4'd6,  5'd23, 16'hFFFF, 16'h0000},  // entry 31
        {1'b0, 4'd6,  5'd20, 16'h5C1F, 16'h0000},
        {1'b0, 4'd7,  5'd20, 16'h9FE0, 16'h0000},
        {1'b1, 4'd7,  5'd21, 16'h0000, 16'hFFFF},
        {1'b0, 4'd5,  5'd20, 16'h0000, 16'h0000},  // R5 close
        {1'b1, 4'd11, 5'd22, 16'h0000, 16'h0000}   // unmapped
    };

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic chk(input logic [4:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata, exp);
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(5'd20, 16'h0000, "R1");
        chk(5'd21, 16'h0000, "R1");
        chk(5'd23, 16'h0000, "R1");
        // R8 locked write command to bank3 entry7
        wr(5'd23, 16'h7777);
        wr(5'd20, 16'h5C07);
        chk(5'd21, 16'h0000, "R8");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41])
                chk(VEC[i][36:32], VEC[i][15:0], $sformatf("R%0d", VEC[i][40:37]));
            else
                wr(VEC[i][36:32], VEC[i][31:16]);
        end

        // R4 broken sequences do not open
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400); wr(5'd20, 16'h0400);
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
        wr(5'd20, 16'h9CA0);
        chk(5'd21, 16'hFFFF, "R4");
        // R4 zero in wrong place restarts the sequence
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400); wr(5'd20, 16'h0000);
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400); wr(5'd20, 16'h0000);
        wr(5'd20, 16'h0400);
        wr(5'd20, 16'h9CA0);
        chk(5'd21, 16'h1234, "R4");
        // R5 nonzero word with test-mode clear locks
        wr(5'd20, 16'h0001);
        wr(5'd20, 16'h9FE0);
        chk(5'd21, 16'h1234, "R5");

        // R1 reset clears bank contents
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(5'd21, 16'h0000, "R1");
        unlock();
        wr(5'd20, 16'h9CA0);
        chk(5'd21, 16'h0000, "R1");
        wr(5'd20, 16'h9FE0);
        chk(5'd21, 16'h0000, "R1");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule